// File: doc/BRIEF.md
# Multi-Processor Interval and User Timer Block

This block holds one system timer and a set of per-processor timers behind a single 32-bit, word-addressed register port. Every timer advances on a shared `tick` strobe, the time base that a prescaler elsewhere produces. The system timer always works as a limit counter. It also carries a mode register that has one bit per processor.

Each processor timer runs in one of two modes. As a limit counter it counts ticks up to a programmable 32-bit period, then flags the event and raises its interrupt line. As a user timer it is a 64-bit up-counter that software loads in two 32-bit halves and starts or stops explicitly.

Writing the mode register moves only those processors whose bit actually changes. Each direction of change has its own clean-up sequence. Reads are combinational on the port. A read of the first register of a timer also acknowledges that timer's interrupt.

Top module: `mpt_top`

## Requirements
- R1: Processor timer p decodes byte addresses 0x10*p to 0x10*p+0xC. Offset 0x0 is the limit or high-count register, 0x4 is the count or low-count register, 0x8 is control/status and 0xC is reserved. The system timer decodes 0x40 to 0x53 with the same first three offsets, and its mode register is at 0x50. Addresses that are unmapped or whose two low bits are not zero read as 0, and writes to them are ignored.
- R2: After reset every processor is in limit-counter mode. All counts and limits are zero, all interrupts are low, the mode register reads 0, and control/status reads 0x1.
- R3: In limit-counter mode the count rises by one on each tick. On the tick that would make it equal to a nonzero limit L, the count returns to 0, the reached flag (status bit 1) sets and the interrupt goes high, so one event occurs every L ticks.
- R4: A limit of zero selects free-run. The count keeps rising past any small value and wraps only from 0xFFFFFFFF to 0.
- R5: In limit-counter mode, a write to offset 0x0 stores the limit, restarts the count at 0, clears the reached flag and lowers the interrupt.
- R6: A read of offset 0x0 clears the reached flag and lowers the interrupt, in either mode. If a terminal tick lands in the same cycle, the new event wins.
- R7: Bit p of the mode register selects user-timer mode for processor p when it is 1, and the register reads back the written value.
- R8: A 0-to-1 change of a mode bit lowers that interrupt, stops the timer (status bit 0 reads 0) and zeroes the count. A 1-to-0 change zeroes the count and starts the counter (status bit 0 reads 1).
- R9: In user-timer mode, offset 0x0 writes and reads the upper 32 count bits and offset 0x4 the lower 32. Each write leaves the other half alone and clears the reached flag.
- R10: A user timer advances only while control bit 0 is 1. In limit-counter mode, control writes are ignored and the counter always runs.
- R11: A user timer at 0xFFFFFFFF_FFFFFFFF wraps to 0 on the next tick, which sets the reached flag and raises the interrupt.
- R12: The system timer follows R3 to R6 and is not affected by mode-register writes.
- R13: Rewriting a mode bit with its current value leaves that processor's count, run state and interrupt untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe shared by all timers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledges on offset 0x0) |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_irq | output | 1 | System timer interrupt |
| cpu_irq | output | NPROC (4) | Per-processor timer interrupts |

## Verification
The hardest state to reach from the ports is the 64-bit user-timer wrap, because ticking there from zero is not feasible. The stimulus loads both halves with a value a few counts short of all ones, then starts the timer so that the wrap happens within a handful of ticks. The second hard case is a read acknowledge landing in the same cycle as a terminal tick. The bench counts ticks against a known limit so that the read is issued on exactly the terminal cycle. A behavioural model tracks every timer's count, flags and mode, and the bench compares it with the interrupt lines and read data on every clock.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int REG_W    = 32;
  localparam int SYS_SPAN = 20;  // bytes in the system window

  typedef logic [REG_W-1:0] word_t;

  // register indexes inside a window (byte offset >> 2)
  localparam logic [2:0] IDX_LIMIT  = 3'd0;
  localparam logic [2:0] IDX_COUNT  = 3'd1;
  localparam logic [2:0] IDX_CTRL   = 3'd2;
  localparam logic [2:0] IDX_CONFIG = 3'd4;

  // true when one more step of cnt hits the period set by lim (0 = 2^REG_W)
  function automatic logic lim_terminal(input word_t cnt, input word_t lim);
    logic [REG_W:0] nxt;
    logic [REG_W:0] per;
    nxt = {1'b0, cnt} + {{REG_W{1'b0}}, 1'b1};
    per = (lim == '0) ? {1'b1, {REG_W{1'b0}}} : {1'b0, lim};
    return nxt == per;
  endfunction
endpackage

// File: rtl/mpt_decode.sv
module mpt_decode #(
  parameter int NPROC    = 4,
  parameter int AW       = 8,
  parameter int SYS_BASE = 64
) (
  input  logic [AW-1:0]    addr,
  output logic [NPROC-1:0] proc_sel,
  output logic             sys_sel,
  output logic [2:0]       idx
);
  import mpt_pkg::*;
  localparam int PW = AW - 4;
  localparam logic [AW-1:0] SYS_LO = AW'(SYS_BASE);
  localparam logic [AW-1:0] SYS_HI = AW'(SYS_BASE + SYS_SPAN);

  logic aligned;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    sys_sel = aligned && (addr >= SYS_LO) && (addr < SYS_HI);
    idx     = sys_sel ? addr[4:2] : {1'b0, addr[3:2]};
  end

  generate
    for (genvar g = 0; g < NPROC; g++) begin : g_psel
      assign proc_sel[g] = aligned && (addr[AW-1:4] == PW'(g));
    end
  endgenerate
endmodule

// File: rtl/mpt_sys_timer.sv
module mpt_sys_timer
  import mpt_pkg::*;
#(
  parameter int NPROC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       idx,
  input  word_t            wdata,
  output word_t            rdata,
  output logic             irq,
  output logic [NPROC-1:0] cfg,
  output logic [NPROC-1:0] to_user,
  output logic [NPROC-1:0] to_cnt
);
  word_t            limit_q, limit_d, count_q, count_d;
  logic             reached_q, reached_d, irq_q, irq_d;
  logic [NPROC-1:0] cfg_q, cfg_d;
  logic             fire, wr_lim, rd_lim, wr_cfg;

  always_comb begin
    fire    = tick && lim_terminal(count_q, limit_q);
    wr_lim  = sel && wr && (idx == IDX_LIMIT);
    rd_lim  = sel && rd && (idx == IDX_LIMIT);
    wr_cfg  = sel && wr && (idx == IDX_CONFIG);
    to_user = wr_cfg ? (wdata[NPROC-1:0] & ~cfg_q) : '0;
    to_cnt  = wr_cfg ? (~wdata[NPROC-1:0] & cfg_q) : '0;
  end

  always_comb begin
    limit_d   = limit_q;
    count_d   = count_q;
    reached_d = reached_q;
    irq_d     = irq_q;
    cfg_d     = cfg_q;
    if (tick) count_d = fire ? '0 : count_q + word_t'(1);
    if (fire) begin
      reached_d = 1'b1;
      irq_d     = 1'b1;
    end
    if (rd_lim && !fire) begin
      reached_d = 1'b0;
      irq_d     = 1'b0;
    end
    if (wr_lim) begin
      limit_d   = wdata;
      count_d   = '0;
      reached_d = 1'b0;
      irq_d     = 1'b0;
    end
    if (wr_cfg) cfg_d = wdata[NPROC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q   <= '0;
      count_q   <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      cfg_q     <= '0;
    end else begin
      limit_q   <= limit_d;
      count_q   <= count_d;
      reached_q <= reached_d;
      irq_q     <= irq_d;
      cfg_q     <= cfg_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_LIMIT:  rdata = limit_q;
      IDX_COUNT:  rdata = count_q;
      IDX_CTRL:   rdata = {{(REG_W-2){1'b0}}, reached_q, 1'b1};
      IDX_CONFIG: rdata = {{(REG_W-NPROC){1'b0}}, cfg_q};
      default:    rdata = '0;
    endcase
  end

  assign irq = irq_q;
  assign cfg = cfg_q;

  // R3
  sys_irq_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> reached_q);

  // R5
  sys_limwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (!irq_q && count_q == '0));
endmodule

// File: rtl/mpt_proc_timer.sv
module mpt_proc_timer
  import mpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [2:0] idx,
  input  word_t      wdata,
  input  logic       user_mode,
  input  logic       go_user,
  input  logic       go_cnt,
  output word_t      rdata,
  output logic       irq
);
  localparam int CW = 2 * REG_W;

  word_t         limit_q, limit_d;
  logic [CW-1:0] count_q, count_d;
  logic          reached_q, reached_d, irq_q, irq_d, run_q, run_d;
  logic          wr_lim, wr_cnt, wr_ctl, rd_lim, term, adv, fire;

  always_comb begin
    wr_lim = sel && wr && (idx == IDX_LIMIT);
    wr_cnt = sel && wr && (idx == IDX_COUNT);
    wr_ctl = sel && wr && (idx == IDX_CTRL);
    rd_lim = sel && rd && (idx == IDX_LIMIT);
    term   = user_mode ? (&count_q) : lim_terminal(count_q[REG_W-1:0], limit_q);
    adv    = tick && run_q;
    fire   = adv && term;
  end

  always_comb begin
    limit_d   = limit_q;
    count_d   = count_q;
    reached_d = reached_q;
    irq_d     = irq_q;
    run_d     = run_q;
    if (adv) begin
      if (term)           count_d = '0;
      else if (user_mode) count_d = count_q + CW'(1);
      else                count_d = {{REG_W{1'b0}}, count_q[REG_W-1:0] + word_t'(1)};
    end
    if (fire) begin
      reached_d = 1'b1;
      irq_d     = 1'b1;
    end
    if (rd_lim && !fire) begin
      reached_d = 1'b0;
      irq_d     = 1'b0;
    end
    if (user_mode) begin
      if (wr_lim) begin
        count_d[CW-1:REG_W] = wdata;
        reached_d           = 1'b0;
      end
      if (wr_cnt) begin
        count_d[REG_W-1:0] = wdata;
        reached_d          = 1'b0;
      end
      if (wr_ctl) run_d = wdata[0];
    end else if (wr_lim) begin
      limit_d   = wdata;
      count_d   = '0;
      reached_d = 1'b0;
      irq_d     = 1'b0;
    end
    if (go_user) begin
      irq_d   = 1'b0;
      run_d   = 1'b0;
      count_d = '0;
    end
    if (go_cnt) begin
      run_d   = 1'b1;
      count_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q   <= '0;
      count_q   <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      run_q     <= 1'b1;
    end else begin
      limit_q   <= limit_d;
      count_q   <= count_d;
      reached_q <= reached_d;
      irq_q     <= irq_d;
      run_q     <= run_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_LIMIT: rdata = user_mode ? count_q[CW-1:REG_W] : limit_q;
      IDX_COUNT: rdata = count_q[REG_W-1:0];
      IDX_CTRL:  rdata = {{(REG_W-2){1'b0}}, reached_q, run_q};
      default:   rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R10
  run_in_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> run_q);

  // R8
  to_user_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_user |=> (!irq_q && !run_q && count_q == '0));

  // R8
  to_cnt_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_cnt |=> (run_q && count_q == '0));

  // R10
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !run_q && !(sel && wr) && !go_cnt) |=> $stable(count_q));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !fire) |=> !irq_q);
endmodule

// File: rtl/mpt_top.sv
module mpt_top
  import mpt_pkg::*;
#(
  parameter int NPROC    = 4,
  parameter int AW       = 8,
  parameter int SYS_BASE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             sys_irq,
  output logic [NPROC-1:0] cpu_irq
);
  logic [NPROC-1:0] proc_sel, cfg, to_user, to_cnt;
  logic             sys_sel;
  logic [2:0]       idx;
  word_t            sys_rd;
  word_t            proc_rd [NPROC];

  mpt_decode #(.NPROC(NPROC), .AW(AW), .SYS_BASE(SYS_BASE)) u_dec (
    .addr(bus_addr), .proc_sel(proc_sel), .sys_sel(sys_sel), .idx(idx)
  );

  mpt_sys_timer #(.NPROC(NPROC)) u_sys (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sys_sel), .wr(bus_wr),
    .rd(bus_rd), .idx(idx), .wdata(bus_wdata), .rdata(sys_rd),
    .irq(sys_irq), .cfg(cfg), .to_user(to_user), .to_cnt(to_cnt)
  );

  generate
    for (genvar g = 0; g < NPROC; g++) begin : g_proc
      mpt_proc_timer u_pt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel(proc_sel[g]),
        .wr(bus_wr), .rd(bus_rd), .idx(idx), .wdata(bus_wdata),
        .user_mode(cfg[g]), .go_user(to_user[g]), .go_cnt(to_cnt[g]),
        .rdata(proc_rd[g]), .irq(cpu_irq[g])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = sys_sel ? sys_rd : '0;
    for (int i = 0; i < NPROC; i++) begin
      if (proc_sel[i]) bus_rdata = proc_rd[i];
    end
  end
endmodule

// File: tb/mpt_top_bench.sv
`timescale 1ns/1ps
module mpt_top_bench;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n, tick, bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sys_irq;
  logic [NP-1:0] cpu_irq;

  int n_chk = 0;
  int n_fail = 0;

  // reference state: index 0..3 processors, 4 system timer
  logic [63:0] m_cnt [5];
  logic [31:0] m_lim [5];
  bit          m_rch [5];
  bit          m_irq [5];
  bit          m_run [5];
  bit          m_usr [5];
  logic [3:0]  m_cfg;

  always #4 clk = ~clk;

  mpt_top u_mpt_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_irq(sys_irq), .cpu_irq(cpu_irq)
  );

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int tgt(input logic [7:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a < 8'h40) return int'(a >> 4) < NP ? int'(a >> 4) : -1;
    if (a < 8'h54) return 4;
    return -1;
  endfunction

  function automatic int widx(input logic [7:0] a);
    if (tgt(a) == 4) return int'(a - 8'h40) >> 2;
    return int'(a & 8'h0F) >> 2;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int t = tgt(a);
    int i = widx(a);
    if (t < 0) return 32'h0;
    case (i)
      0: return m_usr[t] ? m_cnt[t][63:32] : m_lim[t];
      1: return m_cnt[t][31:0];
      2: return {30'h0, m_rch[t], m_run[t]};
      4: return (t == 4) ? {28'h0, m_cfg} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_update(input bit w, input bit r, input logic [7:0] a,
                              input logic [31:0] d, input bit tk);
    bit fire [5];
    int t, i;
    for (int k = 0; k < 5; k++) begin
      fire[k] = 1'b0;
      if (tk && m_run[k]) begin
        if (m_usr[k]) begin
          if (m_cnt[k] == 64'hFFFF_FFFF_FFFF_FFFF) begin m_cnt[k] = 0; fire[k] = 1; end
          else m_cnt[k] = m_cnt[k] + 1;
        end else begin
          longint unsigned period = (m_lim[k] == 0) ? 64'h1_0000_0000 : 64'(m_lim[k]);
          if (64'(m_cnt[k]) + 1 == period) begin m_cnt[k] = 0; fire[k] = 1; end
          else m_cnt[k] = m_cnt[k] + 1;
        end
        if (fire[k]) begin m_rch[k] = 1; m_irq[k] = 1; end
      end
    end
    t = tgt(a);
    i = widx(a);
    if (t >= 0) begin
      if (r && i == 0 && !fire[t]) begin m_rch[t] = 0; m_irq[t] = 0; end
      if (w) begin
        if (t < 4 && m_usr[t]) begin
          if (i == 0) begin m_cnt[t][63:32] = d; m_rch[t] = 0; end
          if (i == 1) begin m_cnt[t][31:0] = d; m_rch[t] = 0; end
          if (i == 2) m_run[t] = d[0];
        end else if (i == 0) begin
          m_lim[t] = d; m_cnt[t] = 0; m_rch[t] = 0; m_irq[t] = 0;
        end
        if (t == 4 && i == 4) begin
          for (int p = 0; p < NP; p++) begin
            if (d[p] && !m_usr[p]) begin
              m_usr[p] = 1; m_irq[p] = 0; m_run[p] = 0; m_cnt[p] = 0;
            end else if (!d[p] && m_usr[p]) begin
              m_usr[p] = 0; m_run[p] = 1; m_cnt[p] = 0;
            end
          end
          m_cfg = d[3:0];
        end
      end
    end
  endtask

  // one clock of bus activity; entered and left at a falling edge
  task automatic step(input bit w, input bit r, input logic [7:0] a,
                      input logic [31:0] d, input bit tk, input string req);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick = tk;
    #1;
    if (r) check(req, $sformatf("read %02h", a), 64'(bus_rdata), 64'(model_read(a)));
    @(posedge clk);
    model_update(w, r, a, d, tk);
    @(negedge clk);
    check(req, "irq lines", 64'({sys_irq, cpu_irq}),
          64'({m_irq[4], m_irq[3], m_irq[2], m_irq[1], m_irq[0]}));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    step(1, 0, a, d, 0, req);
  endtask
  task automatic rd(input logic [7:0] a, input string req);
    step(0, 1, a, 32'h0, 0, req);
  endtask
  task automatic ticks(input int n, input string req);
    repeat (n) step(0, 0, 8'h0C, 32'h0, 1, req);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    for (int k = 0; k < 5; k++) begin
      m_cnt[k] = 0; m_lim[k] = 0; m_rch[k] = 0; m_irq[k] = 0; m_run[k] = 1; m_usr[k] = 0;
    end
    m_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2", "irq after reset", 64'({sys_irq, cpu_irq}), 64'h0);
    rd(8'h00, "R2"); rd(8'h04, "R2"); rd(8'h08, "R2"); rd(8'h50, "R2"); rd(8'h48, "R2");

    // R1 decode, unmapped, misaligned, reserved
    rd(8'h5C, "R1"); rd(8'h02, "R1");
    wr(8'h0C, 32'hFFFF, "R1"); rd(8'h00, "R1"); rd(8'h0C, "R1");
    wr(8'h03, 32'h9, "R1"); rd(8'h00, "R1");

    // R3 limit counting
    wr(8'h00, 32'd5, "R3");
    ticks(12, "R3");
    rd(8'h04, "R3"); rd(8'h08, "R3");

    // R6 acknowledge, then acknowledge on the terminal tick
    rd(8'h00, "R6"); rd(8'h08, "R6");
    ticks(2, "R6");
    step(0, 1, 8'h00, 32'h0, 1, "R6");
    rd(8'h08, "R6");

    // R5 limit rewrite
    wr(8'h00, 32'd7, "R5"); rd(8'h04, "R5"); rd(8'h08, "R5");

    // R4 free-run with limit zero
    wr(8'h20, 32'd0, "R4");
    ticks(40, "R4");
    rd(8'h24, "R4"); rd(8'h28, "R4");

    // R7 mode register, R8 counter to user
    wr(8'h50, 32'h2, "R7"); rd(8'h50, "R7");
    rd(8'h18, "R8"); ticks(3, "R8"); rd(8'h14, "R8");

    // R9 split load
    wr(8'h10, 32'h1234_5678, "R9"); wr(8'h14, 32'h9ABC_DEF0, "R9");
    rd(8'h10, "R9"); rd(8'h14, "R9");

    // R10 start and stop
    wr(8'h18, 32'h1, "R10"); ticks(5, "R10"); rd(8'h14, "R10");
    wr(8'h18, 32'h0, "R10"); ticks(3, "R10"); rd(8'h14, "R10"); rd(8'h10, "R10");
    wr(8'h08, 32'h0, "R10"); ticks(2, "R10"); rd(8'h08, "R10");

    // R11 64-bit wrap
    wr(8'h10, 32'hFFFF_FFFF, "R11"); wr(8'h14, 32'hFFFF_FFFD, "R11");
    wr(8'h18, 32'h1, "R11"); ticks(4, "R11");
    rd(8'h18, "R11"); rd(8'h10, "R11"); rd(8'h14, "R11");

    // R9 write clears reached
    wr(8'h10, 32'hFFFF_FFFF, "R9"); wr(8'h14, 32'hFFFF_FFFF, "R9");
    ticks(1, "R9"); rd(8'h18, "R9");
    wr(8'h14, 32'h5, "R9"); rd(8'h18, "R9");

    // R13 unchanged bit leaves processor alone
    wr(8'h50, 32'h2, "R13"); rd(8'h14, "R13"); rd(8'h18, "R13");

    // R8 user back to counter
    wr(8'h50, 32'h0, "R8"); rd(8'h18, "R8"); rd(8'h14, "R8");
    ticks(2, "R8"); rd(8'h14, "R8");

    // R12 system timer
    wr(8'h40, 32'd4, "R12"); ticks(4, "R12");
    wr(8'h50, 32'h8, "R12"); ticks(1, "R12");
    rd(8'h44, "R12"); rd(8'h48, "R12"); rd(8'h40, "R12"); rd(8'h48, "R12");
    rd(8'h3C, "R1"); rd(8'h38, "R12");

    summary();
    $finish;
  end
endmodule